// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Unit

This block is the status-register and write-protection part of a serial flash slave sitting behind a mode-0 SPI link. It watches the serial clock, chip select and data-in lines, which it oversamples in its own clock domain. It decodes the instruction byte sent after chip select falls and keeps the status byte: the busy flag, the write-enable latch, three block-protect bits and a status-lock bit. It then decides whether a status write, page program, sector erase or bulk erase is accepted.

An accepted program or erase gives a one-cycle start pulse on a dedicated output and makes the device busy. A counter of `BUSY_CYCLES` system clocks stands in for the internal operation. Reading the status streams the status byte out on the data-out line for as long as chip select stays low. A lock bit combined with a low write-protect pin freezes the protection settings.

Top module: `sflash_wp_unit`

## Requirements
- R1: After reset the status byte reads 0x00, `miso` is 0 and no start pulse is given.
- R2: The status byte is {lock, 0, 0, bp[2:0], wel, wip} (bit7 = lock, bits 4:2 = protect bits, bit1 = write-enable latch, bit0 = busy). After opcode 0x05 it is sent MSB first, changing after falling `sck` edges, and repeats byte after byte while `cs_n` stays low.
- R3: The read-status opcode 0x05 works while the device is busy and reports busy = 1.
- R4: Opcode 0x06 sets the write-enable latch, only if `cs_n` rises right after a whole byte; a rise in the middle of a byte cancels the instruction.
- R5: While the write-enable latch is 0, status write (0x01), page program (0x02), sector erase (0xD8) and bulk erase (0xC7) have no effect and give no pulse.
- R6: An accepted status write (0x01 followed by one data byte) copies data bit7 to lock and data bits 4:2 to the protect bits, and starts a busy cycle; data bits 6 and 5 are dropped.
- R7: When lock = 1 and `wp_n` = 0, a status write is ignored entirely; with `wp_n` = 1 the same write is accepted.
- R8: Bulk erase (0xC7 alone) is accepted only when all three protect bits are 0; a refused bulk erase leaves the status unchanged.
- R9: Sector erase (0xD8 plus exactly three address bytes) pulses `sect_go`, page program (0x02 plus three address bytes and at least one data byte) pulses `prog_go`, and bulk erase pulses `bulk_go`, each also starting a busy cycle; any other byte count is ignored.
- R10: A busy cycle lasts `BUSY_CYCLES` clocks; at its end busy and the write-enable latch both return to 0.
- R11: While busy, every instruction except 0x05 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock, idle low |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data in, sampled on rising `sck` |
| wp_n | input | 1 | Hardware write-protect pin, active low |
| miso | output | 1 | Serial data out (status stream) |
| prog_go | output | 1 | One-cycle pulse: page program accepted |
| sect_go | output | 1 | One-cycle pulse: sector erase accepted |
| bulk_go | output | 1 | One-cycle pulse: bulk erase accepted |

## Verification
The end of a busy cycle, which clears busy and the write-enable latch, can fall in the same stretch as a status stream that is reloading its byte. To provoke this, the bench starts a long continuous status read right after a status write. The read runs across the whole busy window. Each streamed byte must be either the busy pattern 0x03 or the idle pattern 0x00, never a torn mix. The stream must begin busy, end idle and never go back to busy once idle.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'hD8;
  localparam logic [7:0] OP_BE   = 8'hC7;

  typedef enum logic [2:0] {
    REQ_NONE,
    REQ_WREN,
    REQ_WRSR,
    REQ_PP,
    REQ_SE,
    REQ_BE
  } req_e;

  typedef struct packed {
    logic       lock;
    logic [2:0] bp;
    logic       wel;
    logic       wip;
  } sreg_t;

  function automatic logic [7:0] pack_status(sreg_t s);
    return {s.lock, 2'b00, s.bp, s.wel, s.wip};
  endfunction

endpackage

// File: rtl/fsr_link.sv
module fsr_link #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sck,
  input  logic             cs_n,
  input  logic             mosi,
  input  logic             stream_en,
  input  logic [7:0]       status_byte,
  output logic             byte_stb,
  output logic [7:0]       byte_val,
  output logic [CNT_W-1:0] byte_idx,
  output logic             end_stb,
  output logic             end_aligned,
  output logic [CNT_W-1:0] end_count,
  output logic             miso
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sck_q, sck_d, cs_q, cs_d, mosi_q;
  logic [2:0]       bit_cnt;
  logic [CNT_W-1:0] byte_cnt;
  logic [7:0]       shreg;
  logic [7:0]       shadow;
  logic             sck_rise, sck_fall, cs_up;

  assign sck_rise = sck_q & ~sck_d & ~cs_q;
  assign sck_fall = ~sck_q & sck_d & ~cs_q;
  assign cs_up    = cs_q & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q       <= 1'b0;
      sck_d       <= 1'b0;
      cs_q        <= 1'b1;
      cs_d        <= 1'b1;
      mosi_q      <= 1'b0;
      bit_cnt     <= '0;
      byte_cnt    <= '0;
      shreg       <= '0;
      shadow      <= '0;
      byte_stb    <= 1'b0;
      byte_val    <= '0;
      byte_idx    <= '0;
      end_stb     <= 1'b0;
      end_aligned <= 1'b0;
      end_count   <= '0;
      miso        <= 1'b0;
    end else begin
      sck_q    <= sck;
      sck_d    <= sck_q;
      cs_q     <= cs_n;
      cs_d     <= cs_q;
      mosi_q   <= mosi;
      byte_stb <= 1'b0;
      end_stb  <= 1'b0;
      if (cs_q) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        miso     <= 1'b0;
      end else begin
        if (sck_rise) begin
          shreg   <= {shreg[6:0], mosi_q};
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            byte_stb <= 1'b1;
            byte_val <= {shreg[6:0], mosi_q};
            byte_idx <= byte_cnt;
            if (byte_cnt != CNT_MAX) byte_cnt <= byte_cnt + 1'b1;
          end
        end
        if (sck_fall) begin
          if (!stream_en) begin
            miso <= 1'b0;
          end else if (bit_cnt == 3'd0) begin
            shadow <= status_byte;
            miso   <= status_byte[7];
          end else begin
            miso <= shadow[~bit_cnt];
          end
        end
      end
      if (cs_up) begin
        end_stb     <= 1'b1;
        end_aligned <= (bit_cnt == 3'd0);
        end_count   <= byte_cnt;
      end
    end
  end

  // R4: a deselected link always restarts at bit zero
  p_link_idle_r4: assert property (@(posedge clk) disable iff (rst)
    cs_q |=> (bit_cnt == 3'd0 && byte_cnt == '0));

  // R2: nothing is driven out while deselected
  p_quiet_out_r2: assert property (@(posedge clk) disable iff (rst)
    (cs_q && cs_d) |=> !miso);

endmodule

// File: rtl/fsr_decode.sv
module fsr_decode
  import fsr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_stb,
  input  logic [7:0]       byte_val,
  input  logic [CNT_W-1:0] byte_idx,
  input  logic             end_stb,
  input  logic             end_aligned,
  input  logic [CNT_W-1:0] end_count,
  output logic             stream_en,
  output logic             req_stb,
  output req_e             req,
  output logic [7:0]       wr_data
);

  localparam logic [CNT_W-1:0] N1 = CNT_W'(1);
  localparam logic [CNT_W-1:0] N2 = CNT_W'(2);
  localparam logic [CNT_W-1:0] N4 = CNT_W'(4);
  localparam logic [CNT_W-1:0] N5 = CNT_W'(5);

  logic [7:0] opcode;
  req_e       kind;

  always_comb begin
    kind = REQ_NONE;
    if (end_aligned) begin
      unique case (opcode)
        OP_WREN: if (end_count == N1) kind = REQ_WREN;
        OP_WRSR: if (end_count >= N2) kind = REQ_WRSR;
        OP_PP:   if (end_count >= N5) kind = REQ_PP;
        OP_SE:   if (end_count == N4) kind = REQ_SE;
        OP_BE:   if (end_count == N1) kind = REQ_BE;
        default: kind = REQ_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opcode    <= '0;
      wr_data   <= '0;
      stream_en <= 1'b0;
      req_stb   <= 1'b0;
      req       <= REQ_NONE;
    end else begin
      req_stb <= 1'b0;
      if (byte_stb) begin
        if (byte_idx == '0) begin
          opcode    <= byte_val;
          stream_en <= (byte_val == OP_RDSR);
        end
        if (byte_idx == N1) wr_data <= byte_val;
      end
      if (end_stb) begin
        stream_en <= 1'b0;
        req       <= kind;
        req_stb   <= (kind != REQ_NONE);
      end
    end
  end

endmodule

// File: rtl/fsr_guard.sv
module fsr_guard
  import fsr_pkg::*;
#(
  parameter int BUSY_CYCLES = 600
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wp_n,
  input  logic       req_stb,
  input  req_e       req,
  input  logic [7:0] wr_data,
  output sreg_t      st,
  output logic       prog_go,
  output logic       sect_go,
  output logic       bulk_go
);

  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic          wp_q;
  logic          hpm;
  logic [CW-1:0] cnt;
  logic          take;

  assign hpm  = st.lock & ~wp_q;
  assign take = req_stb & ~st.wip;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q    <= 1'b1;
      st      <= '0;
      cnt     <= '0;
      prog_go <= 1'b0;
      sect_go <= 1'b0;
      bulk_go <= 1'b0;
    end else begin
      wp_q    <= wp_n;
      prog_go <= 1'b0;
      sect_go <= 1'b0;
      bulk_go <= 1'b0;
      if (st.wip) begin
        if (cnt <= CW'(1)) begin
          st.wip <= 1'b0;
          st.wel <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (take) begin
        unique case (req)
          REQ_WREN: st.wel <= 1'b1;
          REQ_WRSR: if (st.wel && !hpm) begin
            st.lock <= wr_data[7];
            st.bp   <= wr_data[4:2];
            st.wip  <= 1'b1;
            cnt     <= CW'(BUSY_CYCLES);
          end
          REQ_PP: if (st.wel) begin
            prog_go <= 1'b1;
            st.wip  <= 1'b1;
            cnt     <= CW'(BUSY_CYCLES);
          end
          REQ_SE: if (st.wel) begin
            sect_go <= 1'b1;
            st.wip  <= 1'b1;
            cnt     <= CW'(BUSY_CYCLES);
          end
          REQ_BE: if (st.wel && st.bp == 3'b000) begin
            bulk_go <= 1'b1;
            st.wip  <= 1'b1;
            cnt     <= CW'(BUSY_CYCLES);
          end
          default: ;
        endcase
      end
    end
  end

  // R5: a start pulse only comes with the latch set and busy raised
  p_wel_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (prog_go || sect_go || bulk_go) |-> (st.wel && st.wip));

  // R7: protected mode freezes lock and protect bits
  p_hpm_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    (st.lock && !wp_q) |=> $stable({st.lock, st.bp}));

  // R8: bulk erase never starts over a protected area
  p_bulk_bp_r8: assert property (@(posedge clk) disable iff (rst)
    bulk_go |-> (st.bp == 3'b000));

  // R10: the end of a busy cycle leaves the latch cleared
  p_done_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(st.wip) |-> !st.wel);

  // R11: nothing can set the latch while busy
  p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
    st.wip |=> !$rose(st.wel));

endmodule

// File: rtl/sflash_wp_unit.sv
module sflash_wp_unit
  import fsr_pkg::*;
#(
  parameter int BUSY_CYCLES = 600,
  parameter int CNT_W       = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  input  logic wp_n,
  output logic miso,
  output logic prog_go,
  output logic sect_go,
  output logic bulk_go
);

  logic             byte_stb, end_stb, end_aligned, stream_en, req_stb;
  logic [7:0]       byte_val, wr_data;
  logic [CNT_W-1:0] byte_idx, end_count;
  req_e             req;
  sreg_t            st;

  fsr_link #(.CNT_W(CNT_W)) u_link (
    .clk         (clk),
    .rst         (rst),
    .sck         (sck),
    .cs_n        (cs_n),
    .mosi        (mosi),
    .stream_en   (stream_en),
    .status_byte (pack_status(st)),
    .byte_stb    (byte_stb),
    .byte_val    (byte_val),
    .byte_idx    (byte_idx),
    .end_stb     (end_stb),
    .end_aligned (end_aligned),
    .end_count   (end_count),
    .miso        (miso)
  );

  fsr_decode #(.CNT_W(CNT_W)) u_decode (
    .clk         (clk),
    .rst         (rst),
    .byte_stb    (byte_stb),
    .byte_val    (byte_val),
    .byte_idx    (byte_idx),
    .end_stb     (end_stb),
    .end_aligned (end_aligned),
    .end_count   (end_count),
    .stream_en   (stream_en),
    .req_stb     (req_stb),
    .req         (req),
    .wr_data     (wr_data)
  );

  fsr_guard #(.BUSY_CYCLES(BUSY_CYCLES)) u_guard (
    .clk     (clk),
    .rst     (rst),
    .wp_n    (wp_n),
    .req_stb (req_stb),
    .req     (req),
    .wr_data (wr_data),
    .st      (st),
    .prog_go (prog_go),
    .sect_go (sect_go),
    .bulk_go (bulk_go)
  );

  // R9: at most one kind of operation starts in a cycle
  p_one_start_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({prog_go, sect_go, bulk_go}));

endmodule

// File: tb/test_sflash_wp_unit.sv
module test_sflash_wp_unit;

  localparam int BUSY = 600;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic wp_n = 1'b1;
  logic miso, prog_go, sect_go, bulk_go;

  int n_chk = 0;
  int n_bad = 0;
  int n_prog = 0, n_sect = 0, n_bulk = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] raw_q[$];
  int         mon_mode = 0;
  int         mbit = 0;
  logic [7:0] mshift = '0;

  always #5 clk = ~clk;

  sflash_wp_unit #(.BUSY_CYCLES(BUSY)) i_sflash_wp_unit (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi), .wp_n(wp_n),
    .miso(miso), .prog_go(prog_go), .sect_go(sect_go), .bulk_go(bulk_go)
  );

  always @(posedge clk) begin
    if (prog_go) n_prog++;
    if (sect_go) n_sect++;
    if (bulk_go) n_bulk++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: captures streamed status bytes and scores them
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      mbit = 0;
    end else if (mon_mode != 0) begin
      if (mbit >= 8) begin
        mshift = {mshift[6:0], miso};
        if ((mbit % 8) == 7) begin
          if (mon_mode == 2) begin
            raw_q.push_back(mshift);
          end else if (exp_q.size() == 0) begin
            chk(1'b0, "R2 extra byte", mshift, 0);
          end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(mshift == e, t, mshift, e);
          end
        end
      end
      mbit++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      @(negedge clk);
      mosi = b[i];
      idle(HALF);
      sck = 1'b1;
      idle(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic sel;
    @(negedge clk);
    cs_n = 1'b0;
    idle(HALF);
  endtask

  task automatic desel;
    idle(HALF);
    cs_n = 1'b1;
    idle(8);
  endtask

  task automatic cmd(input logic [7:0] op);
    sel();
    send_bits(op, 8);
    desel();
  endtask

  task automatic wrsr(input logic [7:0] d);
    sel();
    send_bits(8'h01, 8);
    send_bits(d, 8);
    desel();
  endtask

  task automatic rdsr(input int n, input logic [7:0] e, input string tag);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    mon_mode = 1;
    sel();
    send_bits(8'h05, 8);
    for (int k = 0; k < n; k++) send_bits(8'h00, 8);
    desel();
    mon_mode = 0;
    chk(exp_q.size() == 0, {tag, " missing bytes"}, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(5);
    // R1 reset state
    chk(miso == 1'b0, "R1 miso after reset", miso, 0);
    chk({prog_go, sect_go, bulk_go} == 3'b000, "R1 pulses after reset",
        {prog_go, sect_go, bulk_go}, 0);
    rdsr(1, 8'h00, "R1 status after reset");

    // R4 write enable cut mid-byte is cancelled
    sel();
    send_bits(8'h06, 8);
    send_bits(8'h00, 3);
    desel();
    rdsr(1, 8'h00, "R4 unaligned wren");

    // R5 no latch: writes and erases refused
    wrsr(8'h9C);
    rdsr(1, 8'h00, "R5 wrsr without wel");
    sel(); send_bits(8'h02, 8);
    for (int k = 0; k < 4; k++) send_bits(8'hA5, 8);
    desel();
    cmd(8'hC7);
    chk(n_prog == 0 && n_bulk == 0, "R5 pulses without wel", n_prog + n_bulk, 0);
    rdsr(1, 8'h00, "R5 status without wel");

    // R4 / R2 write enable and repeated stream
    cmd(8'h06);
    rdsr(3, 8'h02, "R2 R4 repeated status with wel");

    // R6 / R3 status write, read while busy
    wrsr(8'h6C);
    rdsr(2, 8'h0F, "R3 R6 busy read after wrsr");
    // R11 write while busy is ignored
    wrsr(8'h00);
    idle(BUSY + 100);
    rdsr(1, 8'h0C, "R10 R11 after busy");

    // R8 bulk erase refused with protect bits set
    cmd(8'h06);
    cmd(8'hC7);
    chk(n_bulk == 0, "R8 refused bulk pulse", n_bulk, 0);
    rdsr(1, 8'h0E, "R8 refused bulk status");

    // R7 lock with wp_n high accepted
    wrsr(8'h8C);
    idle(BUSY + 100);
    rdsr(1, 8'h8C, "R7 lock set");
    wp_n = 1'b0;
    cmd(8'h06);
    wrsr(8'h00);
    rdsr(1, 8'h8E, "R7 protected write ignored");
    wp_n = 1'b1;
    idle(4);
    wrsr(8'h00);
    idle(BUSY + 100);
    rdsr(1, 8'h00, "R7 unprotected write accepted");

    // R8 / R9 bulk erase allowed
    cmd(8'h06);
    cmd(8'hC7);
    chk(n_bulk == 1, "R8 R9 bulk pulse", n_bulk, 1);
    rdsr(1, 8'h03, "R9 bulk busy");
    idle(BUSY + 100);
    rdsr(1, 8'h00, "R10 bulk done");

    // R9 sector erase exact length and short length
    cmd(8'h06);
    sel(); send_bits(8'hD8, 8);
    for (int k = 0; k < 3; k++) send_bits(8'h10, 8);
    desel();
    chk(n_sect == 1, "R9 sector pulse", n_sect, 1);
    idle(BUSY + 100);
    cmd(8'h06);
    sel(); send_bits(8'hD8, 8);
    for (int k = 0; k < 2; k++) send_bits(8'h10, 8);
    desel();
    chk(n_sect == 1, "R9 short sector ignored", n_sect, 1);
    rdsr(1, 8'h02, "R9 short sector status");

    // R9 page program
    sel(); send_bits(8'h02, 8);
    for (int k = 0; k < 5; k++) send_bits(8'h3C, 8);
    desel();
    chk(n_prog == 1, "R9 program pulse", n_prog, 1);
    idle(BUSY + 100);
    rdsr(1, 8'h00, "R10 program done");

    // R2 R10 continuous stream across busy expiry
    cmd(8'h06);
    wrsr(8'h00);
    raw_q.delete();
    mon_mode = 2;
    sel(); send_bits(8'h05, 8);
    for (int k = 0; k < 12; k++) send_bits(8'h00, 8);
    desel();
    mon_mode = 0;
    chk(raw_q.size() == 12, "R2 stream length", raw_q.size(), 12);
    if (raw_q.size() == 12) begin
      bit seen_idle = 0;
      bit ok = 1;
      chk(raw_q[0] == 8'h03, "R3 stream starts busy", raw_q[0], 8'h03);
      chk(raw_q[11] == 8'h00, "R10 stream ends idle", raw_q[11], 8'h00);
      for (int k = 0; k < 12; k++) begin
        if (raw_q[k] != 8'h03 && raw_q[k] != 8'h00) ok = 0;
        if (raw_q[k] == 8'h00) seen_idle = 1;
        else if (seen_idle) ok = 0;
      end
      chk(ok, "R2 R10 stream bytes whole and monotone", ok, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule